// File: doc/BRIEF.md
# SPI Controller Interrupt Status and Enable Logic

This block holds the interrupt registers of a memory-mapped SPI controller and drives its single level-sensitive interrupt line. The FIFO datapath reports what has happened through single-cycle event pulses (receive overrun, transmit empty, transmit underrun, transmit half empty) and through two live levels (receive FIFO holds data, receive FIFO full). The two levels are not latched on every clock. They are folded into the status register only when software touches the register port.

Software sees three 32-bit registers through a simple request/write/address port: a global enable, a latched status word and a per-source enable mask. A status bit is cleared by writing a one to it, which toggles it (XOR), so writing a one to a clear bit sets it. The interrupt line is the registered result of "any enabled status bit set, and global enable on". A one-cycle clear request from the controller's soft-reset path empties all three registers.

Top module: `spi_irq_ctrl`

## Requirements
- R1: After the asynchronous reset is released, the global enable, status and enable registers all read zero and `irq` is low.
- R2: Register map by byte offset: 0x1C holds the global enable in bit 31; 0x20 holds status; 0x28 holds the enable mask. Status and enable use bit 8 = receive not empty, bit 4 = receive full, bit 5 = receive overrun, bit 2 = transmit empty, bit 3 = transmit underrun, bit 6 = transmit half empty. Every other bit reads zero. Any other offset reads zero, and writes to it change nothing.
- R3: A write to offset 0x20 XORs the written data into the stored status bits, so each bit written as one flips.
- R4: Any register access (`reg_req` high, read or write, any offset) sets status bit 8 if `rx_nonempty_lvl` is high and bit 4 if `rx_full_lvl` is high. Without an access, these levels leave the status unchanged.
- R5: A pulse on `rx_overrun_pls`, `tx_empty_pls`, `tx_underrun_pls` or `tx_half_pls` sets status bit 5, 2, 3 or 6 respectively at the next clock edge.
- R6: When an event and a toggle write hit the same status bit in the same cycle, the bit ends up set.
- R7: A `soft_clr` pulse clears status, enable and global enable at the next edge. It overrides any write, event or level in that cycle.
- R8: `irq` is a register. It goes high one clock edge after (status AND enable) becomes nonzero while the global enable is set, and it falls one edge after that condition ends.
- R9: While the global enable bit is clear, `irq` is low one edge later, whatever the status and enable contents are.
- R10: `reg_rdata` is combinational from `reg_addr` and shows the register contents before the current access has any effect.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | Access is a write when high |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| soft_clr | input | 1 | Controller register-reset request |
| rx_nonempty_lvl | input | 1 | Receive FIFO holds data |
| rx_full_lvl | input | 1 | Receive FIFO is full |
| rx_overrun_pls | input | 1 | A received byte was dropped |
| tx_empty_pls | input | 1 | Transmit FIFO drained |
| tx_underrun_pls | input | 1 | Transmit underrun |
| tx_half_pls | input | 1 | Transmit FIFO dropped to half |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its defaults: an 8-bit address, 32-bit data and the offsets 0x1C, 0x20 and 0x28. The unmapped offsets 0x00 to 0xFF can therefore be reached, and the global enable bit sits at bit 31 of a full data word. With these values, directed accesses can test the reserved-bit masking, the toggle/event collisions and the soft clear against a per-clock behavioural model. A long random run then mixes levels, pulses, toggles and clears on every address.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

  // Number of interrupt sources held in the status register
  localparam int NSRC    = 6;
  localparam int GIE_BIT = 31;

  // Source index order used inside the block
  localparam int SRC_RX_NE   = 0;
  localparam int SRC_RX_FULL = 1;
  localparam int SRC_RX_OVR  = 2;
  localparam int SRC_TX_EMP  = 3;
  localparam int SRC_TX_UDR  = 4;
  localparam int SRC_TX_HALF = 5;

  // Bit position of each source inside the software-visible word
  function automatic int src_bit(input int idx);
    case (idx)
      SRC_RX_NE:   return 8;
      SRC_RX_FULL: return 4;
      SRC_RX_OVR:  return 5;
      SRC_TX_EMP:  return 2;
      SRC_TX_UDR:  return 3;
      default:     return 6;
    endcase
  endfunction

  function automatic logic [31:0] src_mask();
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tgl_we_i,
  input  logic [N-1:0] tgl_bits_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] stat_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic cell_q, cell_d, cell_en;

    always_comb begin
      cell_en = clr_i | tgl_we_i | set_i[i];
      if (clr_i) cell_d = 1'b0;
      else       cell_d = (cell_q ^ (tgl_we_i & tgl_bits_i[i])) | set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 1'b0;
      else if (cell_en) cell_q <= cell_d;
    end

    assign stat_o[i] = cell_q;

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && !clr_i) |=> stat_o[i]); // R6
  end

  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (stat_o == '0)); // R7

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !tgl_we_i && (set_i == '0)) |=> $stable(stat_o)); // R4

endmodule

// File: rtl/spi_irq_enable.sv
module spi_irq_enable
  import spi_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         gie_we_i,
  input  logic         gie_bit_i,
  input  logic         en_we_i,
  input  logic [N-1:0] en_bits_i,
  output logic         gie_o,
  output logic [N-1:0] en_o
);

  logic         gie_q, gie_d, gie_ce;
  logic [N-1:0] en_q, en_d;
  logic         en_ce;

  always_comb begin
    gie_ce = clr_i | gie_we_i;
    gie_d  = clr_i ? 1'b0 : gie_bit_i;
    en_ce  = clr_i | en_we_i;
    en_d   = clr_i ? '0 : en_bits_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_ce) gie_q <= gie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign gie_o = gie_q;
  assign en_o  = en_q;

  AST_ENABLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!gie_o && (en_o == '0))); // R7

endmodule

// File: rtl/spi_irq_gate.sv
module spi_irq_gate
  import spi_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic         gie_i,
  output logic         irq_o
);

  logic irq_q, irq_d;

  always_comb irq_d = gie_i & (|(stat_i & en_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |=> !irq_o); // R9

  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_i & en_i) == '0) |=> !irq_o); // R8

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] GIE_OFS  = 'h1C,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h20,
  parameter logic [ADDR_W-1:0] EN_OFS   = 'h28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              soft_clr,
  input  logic              rx_nonempty_lvl,
  input  logic              rx_full_lvl,
  input  logic              rx_overrun_pls,
  input  logic              tx_empty_pls,
  input  logic              tx_underrun_pls,
  input  logic              tx_half_pls,
  output logic              irq
);

  localparam logic [DATA_W-1:0] VIS_MASK = DATA_W'(src_mask());

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_s_n = rsync_q[1];

  // Access decode
  logic wr_gie, wr_stat, wr_en;
  always_comb begin
    wr_gie  = reg_req & reg_wr & (reg_addr == GIE_OFS);
    wr_stat = reg_req & reg_wr & (reg_addr == STAT_OFS);
    wr_en   = reg_req & reg_wr & (reg_addr == EN_OFS);
  end

  // Source set vector: levels only on an access, events any time
  logic [NSRC-1:0] set_v;
  always_comb begin
    set_v              = '0;
    set_v[SRC_RX_NE]   = reg_req & rx_nonempty_lvl;
    set_v[SRC_RX_FULL] = reg_req & rx_full_lvl;
    set_v[SRC_RX_OVR]  = rx_overrun_pls;
    set_v[SRC_TX_EMP]  = tx_empty_pls;
    set_v[SRC_TX_UDR]  = tx_underrun_pls;
    set_v[SRC_TX_HALF] = tx_half_pls;
  end

  // Pick the source bits out of the write data
  logic [NSRC-1:0] wbits;
  for (genvar i = 0; i < NSRC; i++) begin : g_wmap
    assign wbits[i] = reg_wdata[src_bit(i)];
  end

  logic wdata_unused;
  assign wdata_unused = ^(reg_wdata & ~VIS_MASK);

  logic [NSRC-1:0] stat, en;
  logic            gie;

  spi_irq_status #(.N(NSRC)) u_status (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .clr_i      (soft_clr),
    .tgl_we_i   (wr_stat),
    .tgl_bits_i (wbits),
    .set_i      (set_v),
    .stat_o     (stat)
  );

  spi_irq_enable #(.N(NSRC)) u_enable (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .clr_i     (soft_clr),
    .gie_we_i  (wr_gie),
    .gie_bit_i (reg_wdata[GIE_BIT]),
    .en_we_i   (wr_en),
    .en_bits_i (wbits),
    .gie_o     (gie),
    .en_o      (en)
  );

  spi_irq_gate #(.N(NSRC)) u_gate (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .stat_i (stat),
    .en_i   (en),
    .gie_i  (gie),
    .irq_o  (irq)
  );

  // Read mux
  logic [DATA_W-1:0] stat_word, en_word, gie_word;
  always_comb begin
    stat_word = '0;
    en_word   = '0;
    gie_word  = '0;
    for (int i = 0; i < NSRC; i++) begin
      stat_word[src_bit(i)] = stat[i];
      en_word[src_bit(i)]   = en[i];
    end
    gie_word[GIE_BIT] = gie;
  end

  always_comb begin
    if (reg_addr == GIE_OFS)       reg_rdata = gie_word;
    else if (reg_addr == STAT_OFS) reg_rdata = stat_word;
    else if (reg_addr == EN_OFS)   reg_rdata = en_word;
    else                           reg_rdata = '0;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (reg_addr == STAT_OFS || reg_addr == EN_OFS) |-> ((reg_rdata & ~VIS_MASK) == '0)); // R2

  AST_NO_IRQ_IN_RESET: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> !irq); // R1

endmodule

// File: tb/test_spi_irq_ctrl.sv
module test_spi_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_req, reg_wr;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        soft_clr, lvl_ne, lvl_full, p_ovr, p_temp, p_udr, p_half;
  logic        irq;

  always #5 clk = ~clk;

  spi_irq_ctrl i_spi_irq_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_req         (reg_req),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .soft_clr        (soft_clr),
    .rx_nonempty_lvl (lvl_ne),
    .rx_full_lvl     (lvl_full),
    .rx_overrun_pls  (p_ovr),
    .tx_empty_pls    (p_temp),
    .tx_underrun_pls (p_udr),
    .tx_half_pls     (p_half),
    .irq             (irq)
  );

  localparam logic [31:0] MASK = 32'h0000_017C;

  int n_chk = 0;
  int n_fail = 0;

  // Behavioural reference
  logic [31:0] m_stat, m_en;
  logic        m_gie, m_irq;

  always @(posedge clk) begin
    logic [31:0] s;
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_gie = 0; m_irq = 0;
    end else begin
      m_irq = m_gie && ((m_stat & m_en) != 0);
      if (soft_clr) begin
        m_stat = 0; m_en = 0; m_gie = 0;
      end else begin
        if (reg_req && reg_wr && reg_addr == 8'h1C) m_gie = reg_wdata[31];
        if (reg_req && reg_wr && reg_addr == 8'h28) m_en = reg_wdata & MASK;
        s = m_stat;
        if (reg_req && reg_wr && reg_addr == 8'h20) s = s ^ (reg_wdata & MASK);
        if (reg_req && lvl_ne)   s = s | 32'h100;
        if (reg_req && lvl_full) s = s | 32'h010;
        if (p_ovr)  s = s | 32'h020;
        if (p_temp) s = s | 32'h004;
        if (p_udr)  s = s | 32'h008;
        if (p_half) s = s | 32'h040;
        m_stat = s;
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    if (a == 8'h1C) return {m_gie, 31'b0};
    if (a == 8'h20) return m_stat;
    if (a == 8'h28) return m_en;
    return 32'h0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    reg_req = 0; reg_wr = 0; reg_wdata = 0; soft_clr = 0;
    p_ovr = 0; p_temp = 0; p_udr = 0; p_half = 0;
  endtask

  // One clock; compare against the model at the falling edge (R8, R10)
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    chk({31'b0, irq}, {31'b0, m_irq}, "R8 irq vs model");
    chk(reg_rdata, model_rd(reg_addr), "R10 rdata vs model");
  endtask

  task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string req);
    reg_req = 0; reg_addr = a; #1;
    chk(reg_rdata, exp, req);
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d);
    reg_req = 1; reg_wr = w; reg_addr = a; reg_wdata = d;
    tick();
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; idle(); reg_addr = 0; lvl_ne = 0; lvl_full = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(8'h1C, 0, "R1 gie"); peek(8'h20, 0, "R1 status"); peek(8'h28, 0, "R1 enable");
    chk({31'b0, irq}, 0, "R1 irq");

    // R5 events set bits
    p_temp = 1; p_udr = 1; tick(); idle();
    peek(8'h20, 32'h0C, "R5 tx empty/underrun");
    // R4 levels without access do nothing
    lvl_ne = 1; lvl_full = 1; tick(); tick();
    peek(8'h20, 32'h0C, "R4 no access no set");
    // R10 read shows pre-access value, then R4 sets bits 8 and 4
    reg_req = 1; reg_addr = 8'h20; #1;
    chk(reg_rdata, 32'h0C, "R10 read before update");
    tick(); idle();
    peek(8'h20, 32'h11C, "R4 levels on access");
    lvl_ne = 0; lvl_full = 0;

    // R3 toggle writes
    access(1, 8'h20, 32'h104);
    peek(8'h20, 32'h018, "R3 toggle clear");
    access(1, 8'h20, 32'h040);
    peek(8'h20, 32'h058, "R3 toggle set");
    access(1, 8'h20, 32'hFFFF_0003);
    peek(8'h20, 32'h058, "R2 reserved status bits");

    // R6 event beats toggle on bit 3
    p_udr = 1; access(1, 8'h20, 32'h008);
    peek(8'h20, 32'h058, "R6 event wins");

    // R2 enable readback, R9 gating
    access(1, 8'h28, 32'hFFFF_FFFF);
    peek(8'h28, MASK, "R2 enable mask");
    tick(); tick();
    chk({31'b0, irq}, 0, "R9 gie off");
    access(1, 8'h1C, 32'h8000_0000);
    chk({31'b0, irq}, 0, "R8 one-cycle latency");
    tick();
    chk({31'b0, irq}, 1, "R8 irq rises");
    peek(8'h1C, 32'h8000_0000, "R2 gie bit 31");
    access(1, 8'h28, 32'h0);
    tick();
    chk({31'b0, irq}, 0, "R8 irq falls on mask");
    access(1, 8'h28, 32'h020);
    p_ovr = 1; tick(); idle(); tick();
    chk({31'b0, irq}, 1, "R5 overrun raises irq");
    access(1, 8'h1C, 32'h7FFF_FFFF);
    tick();
    chk({31'b0, irq}, 0, "R9 gie cleared");

    // R2 unmapped offset; R4 any address samples levels
    access(1, 8'h40, 32'hFFFF_FFFF);
    peek(8'h40, 0, "R2 unmapped reads zero");
    peek(8'h20, 32'h078, "R2 unmapped write ignored");
    lvl_ne = 1; access(0, 8'h44, 0); lvl_ne = 0;
    peek(8'h20, 32'h178, "R4 any address");

    // R7 soft clear beats events and writes
    access(1, 8'h1C, 32'h8000_0000);
    soft_clr = 1; p_half = 1; access(1, 8'h28, 32'hFFFF_FFFF);
    peek(8'h20, 0, "R7 status cleared");
    peek(8'h28, 0, "R7 enable cleared");
    peek(8'h1C, 0, "R7 gie cleared");
    tick();
    chk({31'b0, irq}, 0, "R7 irq low");

    // Random run against the model
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 7);
      reg_req   = ($urandom_range(0, 2) == 0);
      reg_wr    = $urandom_range(0, 1);
      reg_addr  = (r < 2) ? 8'h1C : (r < 4) ? 8'h20 : (r < 6) ? 8'h28 : 8'($urandom_range(0, 255));
      reg_wdata = $urandom;
      soft_clr  = ($urandom_range(0, 60) == 0);
      lvl_ne    = $urandom_range(0, 1);
      lvl_full  = ($urandom_range(0, 3) == 0);
      p_ovr     = ($urandom_range(0, 9) == 0);
      p_temp    = ($urandom_range(0, 9) == 0);
      p_udr     = ($urandom_range(0, 9) == 0);
      p_half    = ($urandom_range(0, 9) == 0);
      tick();
    end
    idle();
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule